// File: doc/BRIEF.md
# Clock Source Command Controller

This block lets software manage a set of clock oscillators through a small select register and a command strobe. The select register holds a 4-bit source number and a 2-bit start-up code. A command acts on the source named in that register. The available commands turn a source on, turn it off, measure whether it is oscillating, make it the system clock source, or copy the current system source number back into the register. Each source keeps its own enable bit and its own stored start-up code, so several oscillators can run at the same time. The oscillators themselves are outside the block. They appear only as one enable output and one tick input per source.

The five sources are numbered in a fixed way: 0 is the internal RC oscillator, 1 is the 128 kHz watchdog oscillator, 2 is the external clock, 3 is the external crystal, and 4 is the PLL output divided by four. The block does not switch the clock itself. Instead it publishes the number of the system source, and a glitch-free multiplexer outside the block uses it. Before a switch, software runs an availability count on the new source and waits for the sticky ready flag.

Top module: `clk_source_ctrl`

## Requirements
- R1: After reset, only source 0 is enabled and it is the system source. The select register, every stored start-up code, the ready flag and the switch-error bit are all 0.
- R2: When `selWe` is high at a clock edge, both select fields are loaded. An enable command (`cmdOp`=0) sets the enable bit of the selected source and stores the start-up field as that source's code on `srcStartup[2*i+1:2*i]`. Request and switch commands also store the code.
- R3: Enable bits are independent, so enabling one source leaves the other enabled sources running.
- R4: A disable command (`cmdOp`=1) clears the enable bit of the selected source and leaves its stored code unchanged. It is refused when the selected source is the system source, so the system source is always enabled.
- R5: A request command (`cmdOp`=2) clears `ready` at that edge. It then counts the ticks of the addressed source that arrive at later edges while that source is enabled. `ready` is set on tick N, where N is 16, 256, 1024 or 16384 for start-up codes 0, 1, 2 and 3. Ticks of other sources are not counted.
- R6: Once set, `ready` keeps its value until the next request command.
- R7: A switch command (`cmdOp`=3) makes the selected source the system source and clears `switchErr`. It does this only if that source is enabled, it was the subject of the last count, the count has completed with `ready` set, and no count is running. Otherwise `sysSrc` is unchanged and `switchErr` is set.
- R8: A recover command (`cmdOp`=4) writes `sysSrc` into the select source field. It leaves the start-up field unchanged, and it wins over a same-cycle register write.
- R9: Any command whose source number is 5 or more leaves every output unchanged.
- R10: Commands with `cmdOp` values 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selWe | input | 1 | Write strobe for the select register |
| selSrcIn | input | 4 | Source number to write |
| selSutIn | input | 2 | Start-up code to write |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| srcTick | input | 5 | One oscillation tick per source |
| selSrc | output | 4 | Select register source field |
| selSut | output | 2 | Select register start-up field |
| srcEn | output | 5 | Oscillator enable per source |
| srcStartup | output | 10 | Stored start-up code per source |
| sysSrc | output | 4 | Current system clock source number |
| ready | output | 1 | Sticky result of the last availability count |
| switchErr | output | 1 | Last switch command was refused |

## Verification
A bad count length or a count that stalls shows up on `ready`: the flag rises a cycle early or late, or it never rises. That difference appears within at most 16384 ticks of the request. A wrong enable bit or a wrong stored code is visible on `srcEn` and `srcStartup` at the first negative edge after the command. A wrong switch decision is just as quick to see on `sysSrc` and `switchErr`, and later it also shows up through the value that recover returns. The bench compares every output with a behavioural model on every cycle, so a corrupted state is flagged at the cycle where it first reaches a port.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    OP_ENABLE  = 3'd0,
    OP_DISABLE = 3'd1,
    OP_REQUEST = 3'd2,
    OP_SWITCH  = 3'd3,
    OP_RECOVER = 3'd4
  } cmd_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doEnable;
    logic doDisable;
    logic latchSut;
    logic doSwitch;
    logic rejectSwitch;
    logic doRecover;
  } strobes_t;

endpackage

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int NSRC         = 5,
  parameter int SRC_W        = 4,
  parameter int SUT_W        = 2,
  parameter int SUT_LOG2 [4] = '{4, 8, 10, 14}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [SRC_W-1:0] selSrc,
  input  logic [SUT_W-1:0] selSut,
  input  logic [NSRC-1:0]  srcEn,
  input  logic [SRC_W-1:0] sysSrc,
  input  logic [NSRC-1:0]  srcTick,
  output strobes_t         st,
  output logic             ready,
  output logic             busy
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CNT_W = SUT_LOG2[3] + 1;

  logic [IDX_W-1:0] tgt;
  logic             inRange;
  logic             addrCmd;
  logic             swOk;
  logic             startReq;
  logic [IDX_W-1:0] cntSrc;
  logic [SUT_W-1:0] cntSut;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  cmd_op_e          op;

  assign op      = cmd_op_e'(cmdOp);
  assign tgt     = selSrc[IDX_W-1:0];
  assign inRange = (selSrc < SRC_W'(NSRC));
  assign addrCmd = cmdValid && inRange;
  assign swOk    = ready && !busy && (cntSrc == tgt) && srcEn[tgt];
  assign startReq = addrCmd && (op == OP_REQUEST);
  assign limit   = CNT_W'(1) << SUT_LOG2[cntSut];

  always_comb begin
    st              = '0;
    st.doEnable     = addrCmd && (op == OP_ENABLE);
    st.doDisable    = addrCmd && (op == OP_DISABLE) && (selSrc != sysSrc);
    st.latchSut     = addrCmd && (op == OP_ENABLE || op == OP_REQUEST || op == OP_SWITCH);
    st.doSwitch     = addrCmd && (op == OP_SWITCH) && swOk;
    st.rejectSwitch = addrCmd && (op == OP_SWITCH) && !swOk;
    st.doRecover    = cmdValid && (op == OP_RECOVER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      ready  <= 1'b0;
      cnt    <= '0;
      cntSrc <= '0;
      cntSut <= '0;
    end else if (startReq) begin
      busy   <= 1'b1;
      ready  <= 1'b0;
      cnt    <= '0;
      cntSrc <= tgt;
      cntSut <= selSut;
    end else if (busy && srcTick[cntSrc] && srcEn[cntSrc]) begin
      if (cnt == limit - CNT_W'(1)) begin
        busy  <= 1'b0;
        ready <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R5: a new count always begins with the flag low
  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !ready);
  // R5: the flag can only rise at the end of a running count
  assert_ready_from_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(busy));
  // R6: with no count running and no new request, the flag holds
  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable(ready));

endmodule

// File: rtl/clk_src_datapath.sv
module clk_src_datapath
  import clk_src_pkg::*;
#(
  parameter int NSRC      = 5,
  parameter int SRC_W     = 4,
  parameter int SUT_W     = 2,
  parameter int RESET_SRC = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic                  selWe,
  input  logic [SRC_W-1:0]      selSrcIn,
  input  logic [SUT_W-1:0]      selSutIn,
  output logic [SRC_W-1:0]      selSrc,
  output logic [SUT_W-1:0]      selSut,
  output logic [NSRC-1:0]       srcEn,
  output logic [SUT_W*NSRC-1:0] srcStartup,
  output logic [SRC_W-1:0]      sysSrc,
  output logic                  switchErr
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IDX_W-1:0] tgt;
  assign tgt = selSrc[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSrc <= '0;
      selSut <= '0;
    end else begin
      if (selWe) begin
        selSrc <= selSrcIn;
        selSut <= selSutIn;
      end
      if (st.doRecover) selSrc <= sysSrc;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcEn[i]                       <= (i == RESET_SRC);
        srcStartup[SUT_W*i +: SUT_W]   <= '0;
      end else begin
        if (st.doEnable && tgt == IDX_W'(i))       srcEn[i] <= 1'b1;
        else if (st.doDisable && tgt == IDX_W'(i)) srcEn[i] <= 1'b0;
        if (st.latchSut && tgt == IDX_W'(i))
          srcStartup[SUT_W*i +: SUT_W] <= selSut;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysSrc    <= SRC_W'(RESET_SRC);
      switchErr <= 1'b0;
    end else if (st.doSwitch) begin
      sysSrc    <= selSrc;
      switchErr <= 1'b0;
    end else if (st.rejectSwitch) begin
      switchErr <= 1'b1;
    end
  end

  // R4: the source driving the system clock can never be off
  assert_sys_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    srcEn[sysSrc[IDX_W-1:0]]);
  // R9: the system source number stays inside the legal range
  assert_sys_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysSrc < SRC_W'(NSRC));
  // R8: recover returns the system source number
  assert_recover_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.doRecover |=> (selSrc == $past(sysSrc)));

endmodule

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl
  import clk_src_pkg::*;
#(
  parameter int NSRC         = 5,
  parameter int SRC_W        = 4,
  parameter int SUT_W        = 2,
  parameter int RESET_SRC    = 0,
  parameter int SUT_LOG2 [4] = '{4, 8, 10, 14}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  selWe,
  input  logic [SRC_W-1:0]      selSrcIn,
  input  logic [SUT_W-1:0]      selSutIn,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdOp,
  input  logic [NSRC-1:0]       srcTick,
  output logic [SRC_W-1:0]      selSrc,
  output logic [SUT_W-1:0]      selSut,
  output logic [NSRC-1:0]       srcEn,
  output logic [SUT_W*NSRC-1:0] srcStartup,
  output logic [SRC_W-1:0]      sysSrc,
  output logic                  ready,
  output logic                  switchErr
);
  strobes_t st;
  logic     busy;

  clk_src_ctrl #(.NSRC(NSRC), .SRC_W(SRC_W), .SUT_W(SUT_W), .SUT_LOG2(SUT_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .selSrc(selSrc), .selSut(selSut), .srcEn(srcEn), .sysSrc(sysSrc),
    .srcTick(srcTick), .st(st), .ready(ready), .busy(busy)
  );

  clk_src_datapath #(.NSRC(NSRC), .SRC_W(SRC_W), .SUT_W(SUT_W), .RESET_SRC(RESET_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .selWe(selWe), .selSrcIn(selSrcIn),
    .selSutIn(selSutIn), .selSrc(selSrc), .selSut(selSut), .srcEn(srcEn),
    .srcStartup(srcStartup), .sysSrc(sysSrc), .switchErr(switchErr)
  );

  // R7: the system source only moves after a completed count with no count running
  assert_switch_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sysSrc != $past(sysSrc)) |-> ($past(ready) && !$past(busy)));

endmodule

// File: tb/clk_source_ctrl_bench.sv
module clk_source_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selWe = 1'b0;
  logic [3:0] selSrcIn = '0;
  logic [1:0] selSutIn = '0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [4:0] srcTick = '0;
  logic [3:0] selSrc;
  logic [1:0] selSut;
  logic [4:0] srcEn;
  logic [9:0] srcStartup;
  logic [3:0] sysSrc;
  logic       ready, switchErr;

  clk_source_ctrl u_clk_source_ctrl (
    .clk(clk), .rstN(rstN), .selWe(selWe), .selSrcIn(selSrcIn), .selSutIn(selSutIn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .srcTick(srcTick), .selSrc(selSrc),
    .selSut(selSut), .srcEn(srcEn), .srcStartup(srcStartup), .sysSrc(sysSrc),
    .ready(ready), .switchErr(switchErr)
  );

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0;
  logic [4:0] tickMask = '0;
  logic       tickHalf = 1'b0;

  // behavioural reference state
  logic [4:0] mEn = 5'b00001;
  logic [1:0] mSut [5] = '{default: 2'd0};
  logic [3:0] mSys = '0, mSelSrc = '0;
  logic [1:0] mSelSut = '0;
  logic       mReady = 0, mBusy = 0, mErr = 0;
  int         mCnt = 0, mLim = 16, mCntSrc = 0;

  function automatic int limOf(logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 256;
      2'd2: return 1024;
      default: return 16384;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    srcTick <= (tickHalf && cyc[0]) ? 5'b0 : tickMask;
  end

  always @(posedge clk) begin
    if (rstN) begin
      logic [4:0] oEn;
      logic [3:0] t;
      logic oReady, oBusy, ok, start;
      int oCntSrc;
      oEn = mEn; oReady = mReady; oBusy = mBusy; oCntSrc = mCntSrc;
      t = mSelSrc; ok = cmdValid && (t < 5); start = 0;
      if (ok) begin
        case (cmdOp)
          3'd0: begin mEn[t] = 1'b1; mSut[t] = mSelSut; end
          3'd1: if (t != mSys) mEn[t] = 1'b0;
          3'd2: begin start = 1; mSut[t] = mSelSut; end
          3'd3: begin
            mSut[t] = mSelSut;
            if (oEn[t] && oReady && !oBusy && oCntSrc == int'(t)) begin mSys = t; mErr = 0; end
            else mErr = 1;
          end
          default: ;
        endcase
      end
      if (start) begin
        mBusy = 1; mReady = 0; mCnt = 0; mCntSrc = int'(t); mLim = limOf(mSelSut);
      end else if (oBusy && srcTick[oCntSrc] && oEn[oCntSrc]) begin
        mCnt++;
        if (mCnt == mLim) begin mBusy = 0; mReady = 1; end
      end
      if (selWe) begin mSelSrc = selSrcIn; mSelSut = selSutIn; end
      if (cmdValid && cmdOp == 3'd4) mSelSrc = mSys;
    end
  end

  // compare every output against the model on every cycle
  always @(negedge clk) begin
    if (rstN) begin
      chk("R8", "selSrc", selSrc, mSelSrc);
      chk("R2", "selSut", selSut, mSelSut);
      chk("R2", "srcEn", srcEn, mEn);
      for (int i = 0; i < 5; i++) chk("R2", "srcStartup", srcStartup[2*i +: 2], mSut[i]);
      chk("R7", "sysSrc", sysSrc, mSys);
      chk("R5", "ready", ready, mReady);
      chk("R7", "switchErr", switchErr, mErr);
    end
  end

  always @(posedge clk) begin
    if (cyc >= 190000) begin
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic doCmd(int op, int src, int sut);
    @(negedge clk); selWe = 1; selSrcIn = 4'(src); selSutIn = 2'(sut);
    @(negedge clk); selWe = 0; cmdValid = 1; cmdOp = 3'(op);
    @(negedge clk); cmdValid = 0;
  endtask

  task automatic waitReady(int maxCyc);
    for (int i = 0; i < maxCyc && !ready; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "srcEn", srcEn, 5'b00001);
    chk("R1", "sysSrc", sysSrc, 0);
    chk("R1", "ready", ready, 0);
    chk("R1", "switchErr", switchErr, 0);
    chk("R1", "srcStartup", srcStartup, 0);
    chk("R1", "selSrc", selSrc, 0);
    // R2 enable and code store
    doCmd(0, 1, 2);
    chk("R2", "srcEn", srcEn, 5'b00011);
    chk("R2", "startup1", srcStartup[3:2], 2);
    // R3 several sources at once
    doCmd(0, 3, 1);
    chk("R3", "srcEn", srcEn, 5'b01011);
    // R4 disable of system source refused, other disable keeps code
    doCmd(1, 0, 3);
    chk("R4", "srcEn", srcEn, 5'b01011);
    doCmd(1, 3, 3);
    chk("R4", "srcEn", srcEn, 5'b00011);
    chk("R4", "startup3", srcStartup[7:6], 1);
    // R7 switch without a count is refused
    doCmd(3, 1, 2);
    chk("R7", "switchErr", switchErr, 1);
    chk("R7", "sysSrc", sysSrc, 0);
    // R5 count of 16 with ticks every cycle
    tickMask = 5'b11111;
    doCmd(2, 1, 0);
    chk("R5", "ready_start", ready, 0);
    repeat (15) @(negedge clk);
    chk("R5", "ready_15", ready, 0);
    @(negedge clk);
    chk("R5", "ready_16", ready, 1);
    // R7 accepted switch
    doCmd(3, 1, 0);
    chk("R7", "sysSrc", sysSrc, 1);
    chk("R7", "switchErr", switchErr, 0);
    // R8 recover
    doCmd(4, 2, 3);
    chk("R8", "selSrc", selSrc, 1);
    chk("R8", "selSut", selSut, 3);
    // R5 other sources' ticks do not count
    tickMask = 5'b11110;
    doCmd(2, 0, 1);
    repeat (300) @(negedge clk);
    chk("R5", "ready_noticks", ready, 0);
    tickMask = 5'b11111;
    waitReady(400);
    chk("R5", "ready_256", ready, 1);
    // R6 sticky flag
    doCmd(0, 4, 0);
    repeat (50) @(negedge clk);
    chk("R6", "ready_hold", ready, 1);
    // R7 switch to a source whose count was not the last one
    doCmd(3, 4, 0);
    chk("R7", "switchErr_other", switchErr, 1);
    // R9 out-of-range codes
    for (int op = 0; op < 4; op++) doCmd(op, 6, 3);
    chk("R9", "srcEn", srcEn, 5'b10011);
    chk("R9", "ready", ready, 1);
    chk("R9", "sysSrc", sysSrc, 1);
    // R10 unused opcodes
    for (int op = 5; op < 8; op++) doCmd(op, 4, 2);
    chk("R10", "srcEn", srcEn, 5'b10011);
    chk("R10", "startup4", srcStartup[9:8], 0);
    chk("R10", "ready", ready, 1);
    // R4 old system source may now be disabled, new one may not
    doCmd(1, 0, 0);
    doCmd(1, 1, 0);
    chk("R4", "srcEn", srcEn, 5'b10010);
    // R5 long count on a disabled source stalls, then runs at half rate
    tickHalf = 1;
    doCmd(2, 2, 3);
    repeat (100) @(negedge clk);
    chk("R5", "ready_disabled", ready, 0);
    doCmd(3, 2, 3);
    chk("R7", "switch_busy", switchErr, 1);
    doCmd(0, 2, 3);
    waitReady(40000);
    chk("R5", "ready_16384", ready, 1);
    doCmd(3, 2, 3);
    chk("R7", "sysSrc_final", sysSrc, 2);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule